// File: doc/BRIEF.md
# Multi-hart machine timer

This block keeps one 64-bit time counter that every hart in a cluster shares, and one 64-bit compare register for each hart. Each hart receives a level interrupt line. The line is high whenever that hart's compare value is at or below the current time, using an unsigned comparison. The counter advances by one on every cycle in which the tick-enable input is high, so a slow timebase can drive it from the core clock domain.

Software reaches the counter and the compare registers over a simple register bus. The bus carries 4-byte and 8-byte little-endian accesses. A 64-bit register can be read or written as a whole at its base offset. A 4-byte access at byte 0 of the register reaches its low word, and a 4-byte access at byte 4 reaches its high word. Software may overwrite the counter at any time, and the interrupt level of every hart then follows the new value. The number of harts, the compare-array base and the counter base are parameters.

Read data is combinational from the address and size inputs. Writes take effect at the clock edge where `bus_valid` and `bus_write` are both high. Interrupt lines are registered.

Top module: `mtimer_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the counter reads 0 and every interrupt line is low. Every compare register reads as all ones until it is written.
- R2: On each clock edge with `tick` high and no counter write, the counter increases by exactly one. Without `tick` it holds its value.
- R3: A counter write and `tick` in the same cycle leave the written value in the counter, with no increment.
- R4: A compare write uses the access kind: 8-byte at byte 0 replaces all 64 bits, 4-byte at byte 0 replaces bits 31:0, and 4-byte at byte 4 replaces bits 63:32. The other half is left unchanged.
- R5: An 8-byte write at byte 4 of any register changes nothing, and an 8-byte read there returns 0.
- R6: The interrupt line of hart h equals (compare[h] <= counter), as an unsigned 64-bit test on the register values one cycle earlier. Writing a compare value above the counter drops the line after one cycle.
- R7: A counter write re-evaluates every hart's interrupt line against the new value, one cycle later.
- R8: A 4-byte read returns the selected word in bits 31:0, with bits 63:32 zero. A read with address bits 1:0 not zero, or to an address that maps to no register, returns 0. A write to such an address changes nothing.
- R9: Compare register h sits at `CMP_BASE + 8*h`. Accessing it touches no other hart's register.
- R10: A 4-byte counter write at byte 0 replaces bits 31:0, and one at byte 4 replaces bits 63:32. The other half of the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter increment enable |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| bus_rdata | output | 64 | Read data, combinational from address and size |
| irq | output | NUM_HARTS | Per-hart level timer interrupt |

## Verification
Directed sequences cover the following cases:
- Pure ticking, which shows that the counter increments and holds correctly.
- A tick that collides with a counter write, which shows that the write wins.
- Half-word and full-word writes to the counter and to the compare registers, which show the merge rules.
- Writes to compare registers of neighbouring harts, which show that address decoding keeps them apart.

Moving the counter above and then below the compare values shows that every hart's line is re-evaluated. A compare value with bit 63 set shows that the comparison is unsigned and not signed. A long constrained-random run then mixes ticks with accesses of both sizes to every register half and to unmapped addresses. The values are kept small so that the interrupt lines toggle often. The interrupt lines are checked every cycle, and sampled reads are checked against a bench model.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_FULL = 2'd3
    } acc_e;

    typedef struct packed {
        logic sel_time;
        acc_e kind;
    } dec_t;

    function automatic acc_e acc_kind(input logic wide, input logic upper);
        if (wide)
            return upper ? ACC_NONE : ACC_FULL;
        return upper ? ACC_HI : ACC_LO;
    endfunction

    function automatic logic [63:0] merge_word(input logic [63:0] old,
                                               input logic [63:0] wdata,
                                               input acc_e kind);
        case (kind)
            ACC_FULL: return wdata;
            ACC_LO:   return {old[63:32], wdata[31:0]};
            ACC_HI:   return {wdata[31:0], old[31:0]};
            default:  return old;
        endcase
    endfunction

    function automatic logic [63:0] read_view(input logic [63:0] value,
                                              input acc_e kind);
        case (kind)
            ACC_FULL: return value;
            ACC_LO:   return {32'd0, value[31:0]};
            ACC_HI:   return {32'd0, value[63:32]};
            default:  return 64'd0;
        endcase
    endfunction

endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
    import mtmr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_HARTS = 2,
    parameter int CMP_BASE  = 'h4000,
    parameter int TIME_BASE = 'hBFF8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wide,
    output dec_t                 dec,
    output logic [NUM_HARTS-1:0] sel_cmp
);
    localparam int IDX_W = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] CB = ADDR_W'(CMP_BASE);
    localparam logic [ADDR_W-1:0] TB = ADDR_W'(TIME_BASE);

    logic [ADDR_W-1:0] rel;
    logic              in_cmp;
    logic              aligned;

    always_comb begin
        aligned      = (addr[1:0] == 2'b00);
        rel          = addr - CB;
        in_cmp       = (addr >= CB) && (rel[ADDR_W-1:3] < IDX_W'(NUM_HARTS));
        dec.sel_time = (addr[ADDR_W-1:3] == TB[ADDR_W-1:3]);
        dec.kind     = aligned ? acc_kind(wide, addr[2]) : ACC_NONE;
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
        assign sel_cmp[h] = in_cmp && (rel[ADDR_W-1:3] == IDX_W'(h));
    end

endmodule

// File: rtl/mtmr_timebase.sv
module mtmr_timebase
    import mtmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  acc_e        kind,
    input  logic [63:0] wdata,
    output logic [63:0] time_q
);
    always_ff @(posedge clk) begin
        if (rst)
            time_q <= 64'd0;
        else if (wr_en)
            time_q <= merge_word(time_q, wdata, kind);
        else if (tick)
            time_q <= time_q + 64'd1;
    end
endmodule

// File: rtl/mtmr_cmp_slot.sv
module mtmr_cmp_slot
    import mtmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  acc_e        kind,
    input  logic [63:0] wdata,
    input  logic [63:0] time_q,
    output logic [63:0] cmp_q,
    output logic        irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            irq_q <= 1'b0;
        end else begin
            if (wr_en)
                cmp_q <= merge_word(cmp_q, wdata, kind);
            irq_q <= (cmp_q <= time_q);
        end
    end
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtmr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_HARTS = 2,
    parameter int CMP_BASE  = 'h4000,
    parameter int TIME_BASE = 'hBFF8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic                 bus_wide,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] irq
);
    dec_t                   dec;
    logic [NUM_HARTS-1:0]   sel_cmp;
    logic                   wr_cycle;
    logic                   time_wr;
    logic [63:0]            time_q;
    logic [63:0]            cmp_q [NUM_HARTS];
    logic [NUM_HARTS*64-1:0] cmp_flat;

    mtmr_decode #(
        .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS),
        .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
    ) u_dec (
        .addr(bus_addr), .wide(bus_wide), .dec(dec), .sel_cmp(sel_cmp)
    );

    assign wr_cycle = bus_valid && bus_write && (dec.kind != ACC_NONE);
    assign time_wr  = wr_cycle && dec.sel_time;

    mtmr_timebase u_time (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(time_wr),
        .kind(dec.kind), .wdata(bus_wdata), .time_q(time_q)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        mtmr_cmp_slot u_slot (
            .clk(clk), .rst(rst),
            .wr_en(wr_cycle && sel_cmp[h]),
            .kind(dec.kind), .wdata(bus_wdata), .time_q(time_q),
            .cmp_q(cmp_q[h]), .irq_q(irq[h])
        );
        assign cmp_flat[h*64 +: 64] = cmp_q[h];
    end

    always_comb begin
        bus_rdata = 64'd0;
        if (dec.sel_time)
            bus_rdata = read_view(time_q, dec.kind);
        for (int h = 0; h < NUM_HARTS; h++)
            if (sel_cmp[h])
                bus_rdata = read_view(cmp_q[h], dec.kind);
    end

endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker #(
    parameter int NUM_HARTS = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic                    time_wr,
    input logic [63:0]             time_q,
    input logic [NUM_HARTS*64-1:0] cmp_flat,
    input logic [NUM_HARTS-1:0]    irq
);
    // R1: first cycle out of reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (time_q == 64'd0 && irq == '0));

    // R2: tick advances counter by one
    p_tick_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !time_wr) |=> (time_q == $past(time_q) + 64'd1));

    // R2: no tick, no write holds counter
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !time_wr) |=> $stable(time_q));

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
        // R6: rising line only when compare was at or below counter
        p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[h]) |-> $past(cmp_flat[h*64 +: 64] <= time_q));
        // R6: falling line only when compare was above counter
        p_irq_fall_r6: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[h]) |-> $past(cmp_flat[h*64 +: 64] > time_q));
    end
endmodule

bind mtimer_top mtmr_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .time_wr(time_wr),
    .time_q(time_q), .cmp_flat(cmp_flat), .irq(irq)
);

// File: tb/mtimer_top_test.sv
`timescale 1ns/1ps
module mtimer_top_test;
    localparam int AW = 16;
    localparam int NH = 2;
    localparam logic [AW-1:0] CB = 16'h4000;
    localparam logic [AW-1:0] TB = 16'hBFF8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [NH-1:0] irq;

    int nchk = 0;
    int nerr = 0;

    logic [63:0] m_time;
    logic [63:0] m_cmp [NH];
    logic [NH-1:0] m_irq;

    mtimer_top #(.ADDR_W(AW), .NUM_HARTS(NH), .CMP_BASE('h4000), .TIME_BASE('hBFF8)) uut (
        .clk(clk), .rst(rst), .tick(tick), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_wide(bus_wide), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mrg(input logic [63:0] old, input logic [63:0] d,
                                        input logic wide, input logic hi);
        if (wide) return hi ? old : d;
        return hi ? {d[31:0], old[31:0]} : {old[63:32], d[31:0]};
    endfunction

    function automatic logic [63:0] view(input logic [63:0] v, input logic wide, input logic hi);
        if (wide) return hi ? 64'd0 : v;
        return hi ? {32'd0, v[63:32]} : {32'd0, v[31:0]};
    endfunction

    function automatic logic [63:0] exp_read(input logic wide, input logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return 64'd0;
        if (a[AW-1:3] == TB[AW-1:3]) return view(m_time, wide, a[2]);
        for (int h = 0; h < NH; h++)
            if (a[AW-1:3] == CB[AW-1:3] + (AW-3)'(h)) return view(m_cmp[h], wide, a[2]);
        return 64'd0;
    endfunction

    // model update at a clock edge, using the inputs present at that edge
    task automatic model_edge();
        logic time_hit;
        for (int h = 0; h < NH; h++) m_irq[h] = (m_cmp[h] <= m_time);
        time_hit = 1'b0;
        if (bus_valid && bus_write && bus_addr[1:0] == 2'b00) begin
            if (bus_addr[AW-1:3] == TB[AW-1:3] && !(bus_wide && bus_addr[2])) begin
                time_hit = 1'b1;
                m_time = mrg(m_time, bus_wdata, bus_wide, bus_addr[2]);
            end
            for (int h = 0; h < NH; h++)
                if (bus_addr[AW-1:3] == CB[AW-1:3] + (AW-3)'(h))
                    m_cmp[h] = mrg(m_cmp[h], bus_wdata, bus_wide, bus_addr[2]);
        end
        if (!time_hit && tick) m_time = m_time + 64'd1;
    endtask

    task automatic cyc(input logic tk, input logic wr, input logic wide,
                       input logic [AW-1:0] a, input logic [63:0] d);
        tick = tk; bus_valid = wr; bus_write = wr; bus_wide = wide;
        bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        tick = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic rd(input logic wide, input logic [AW-1:0] a, output logic [63:0] v);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wide = wide; bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [AW-1:0] addrs [7];
        void'($urandom(32'd4711));
        addrs[0] = TB; addrs[1] = TB + 16'd4; addrs[2] = CB; addrs[3] = CB + 16'd4;
        addrs[4] = CB + 16'd8; addrs[5] = CB + 16'd12; addrs[6] = 16'h0100;

        m_time = '0; m_irq = '0;
        for (int h = 0; h < NH; h++) m_cmp[h] = '1;
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        chk("R1 irq in reset", 64'(irq), 64'd0);
        rst = 1'b0;
        rd(1'b1, TB, v);           chk("R1 time after reset", v, 64'd0);
        rd(1'b1, CB, v);           chk("R1 cmp0 reset", v, '1);
        rd(1'b1, CB + 16'd8, v);   chk("R1 cmp1 reset", v, '1);
        chk("R1 irq after reset", 64'(irq), 64'd0);

        // R2: ticking and holding
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, '0, '0);
        rd(1'b1, TB, v);           chk("R2 five ticks", v, 64'd5);
        idle(3);
        rd(1'b1, TB, v);           chk("R2 hold without tick", v, 64'd5);

        // R3: write beats tick
        cyc(1'b1, 1'b1, 1'b0, TB, 64'h100);
        rd(1'b1, TB, v);           chk("R3 write over tick", v, 64'h100);

        // R10: counter high half write
        cyc(1'b0, 1'b1, 1'b0, TB + 16'd4, 64'hDEAD_0000_0000_0001);
        rd(1'b1, TB, v);           chk("R10 time high half", v, 64'h1_0000_0100);
        rd(1'b0, TB + 16'd4, v);   chk("R8 narrow high read", v, 64'h1);

        // R6: compare at/below time -> line after one cycle
        cyc(1'b0, 1'b1, 1'b1, CB, 64'h20);
        chk("R6 no change same cycle", 64'(irq[0]), 64'd0);
        idle(1);
        chk("R6 raise after one cycle", 64'(irq[0]), 64'd1);

        // R4: half writes to compare
        cyc(1'b0, 1'b1, 1'b0, CB + 16'd4, 64'h0000_FFFF);
        rd(1'b1, CB, v);           chk("R4 cmp high half", v, 64'h0000_FFFF_0000_0020);
        idle(1);
        chk("R6 drop after raising compare", 64'(irq[0]), 64'd0);
        cyc(1'b0, 1'b1, 1'b0, CB, 64'h5);
        rd(1'b1, CB, v);           chk("R4 cmp low half", v, 64'h0000_FFFF_0000_0005);

        // R5: wide write at byte 4 ignored; wide read there is zero
        cyc(1'b0, 1'b1, 1'b1, CB + 16'd4, 64'h0);
        rd(1'b1, CB, v);           chk("R5 wide hi write ignored", v, 64'h0000_FFFF_0000_0005);
        rd(1'b1, CB + 16'd4, v);   chk("R5 wide hi read zero", v, 64'd0);

        // R9: neighbour hart addressing
        cyc(1'b0, 1'b1, 1'b1, CB + 16'd8, 64'h1_0000_0200);
        rd(1'b1, CB + 16'd8, v);   chk("R9 cmp1 write", v, 64'h1_0000_0200);
        rd(1'b1, CB, v);           chk("R9 cmp0 untouched", v, 64'h0000_FFFF_0000_0005);
        idle(1);
        chk("R6 both low", 64'(irq), 64'd0);

        // R7: counter write re-evaluates harts
        cyc(1'b0, 1'b1, 1'b1, TB, 64'h2_0000_0000);
        idle(1);
        chk("R7 time jump raises hart1", 64'(irq), 64'b10);
        cyc(1'b0, 1'b1, 1'b1, TB, 64'h0);
        idle(1);
        chk("R7 time clear drops hart1", 64'(irq), 64'd0);

        // R6: unsigned compare with bit 63 set
        cyc(1'b0, 1'b1, 1'b1, CB, 64'h8000_0000_0000_0000);
        idle(2);
        chk("R6 unsigned compare", 64'(irq[0]), 64'd0);

        // R8: misaligned / unmapped
        rd(1'b0, CB + 16'd2, v);   chk("R8 misaligned read", v, 64'd0);
        rd(1'b1, 16'h0100, v);     chk("R8 unmapped read", v, 64'd0);
        rd(1'b1, CB + 16'd16, v);  chk("R8 past last hart", v, 64'd0);
        cyc(1'b0, 1'b1, 1'b1, CB + 16'd9, 64'h7);
        rd(1'b1, CB + 16'd8, v);   chk("R8 misaligned write ignored", v, 64'h1_0000_0200);

        // random phase: small values so interrupt lines toggle often
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [63:0] d;
            a = addrs[$urandom % 7];
            d = 64'($urandom % 400);
            if ($urandom % 8 == 0) d = 64'($urandom % 3) << 32 | d;
            cyc(1'($urandom), ($urandom % 4) == 0, 1'($urandom), a, d);
            chk("R6 random irq", 64'(irq), 64'(m_irq));
            if (i % 4 == 0) begin
                logic w;
                w = 1'($urandom);
                a = addrs[$urandom % 7];
                rd(w, a, v);
                chk("R4 R10 random read", v, exp_read(w, a));
            end
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule